// File: doc/BRIEF.md
# Burst beat address and strobe generator

This block takes one write-burst command (start address, size code, beat count minus one, burst type) over a valid/ready handshake. It expands the command into a stream of per-beat records, one per beat, on a second valid/ready handshake. Each record carries the beat address, the byte-lane write-strobe mask for a data bus of `BUS_BYTES` lanes, and a flag on the final beat. It sits inside the write path of a bus master or slave, where it decides which byte lanes every beat may drive.

Each strobe is derived from the actual beat address, so a start address that is not a multiple of the beat size enables only part of the size window. In a fixed burst the address never moves, so that reduced strobe repeats on every beat. In an incrementing burst only the first beat is reduced, because later beats land on size-aligned addresses. Wrapping bursts must start aligned. They fold back to the base of a window whose size is the beat count times the beat size. Illegal commands are consumed, flagged for one cycle, and produce no beats.

Top module: `burst_beat_gen`

## Requirements
- R1: `cmd_ready_o` is high exactly when no burst is in progress. A legal command produces exactly `cmd_len_i`+1 beats, and `beat_last_o` is set on the final beat only. After that beat is handed off, the block is idle in the next cycle.
- R2: Bytes per beat are 2 to the power of `cmd_size_i`. The strobe bits run from the lane position (address modulo `BUS_BYTES`) up to the end of the size-aligned window that holds the address. With an 8-lane bus, address 0x03 and size 1 give strobe 0x08.
- R3: Burst type 2'b00 (fixed): every beat carries the start address and the same strobe.
- R4: Burst type 2'b01 (incrementing): beat 0 uses the start address. Beat n≥1 uses the start address rounded down to the beat size, plus n times the beat size. From 0x03 with size 1, the addresses are 0x03, 0x04, 0x06, 0x08 and the strobes are 0x08, 0x30, 0xC0, 0x03.
- R5: Burst type 2'b10 (wrapping): the window is (len+1)·bytes and is aligned to its own size. Beat n's address is base + ((start − base + n·bytes) mod window).
- R6: A command is illegal if any of the following holds: burst type is 2'b11; the beat size exceeds `BUS_BYTES`; a wrapping command has an unaligned start; or a wrapping command has a beat count other than 2, 4, 8 or 16. An illegal command is accepted and raises `err_o` for exactly one cycle, the cycle after acceptance. It emits no beats. `err_o` stays low for legal commands.
- R7: While `beat_valid_o` is high and `beat_ready_i` is low, the beat record holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Command accepted when high with valid |
| cmd_addr_i | input | ADDR_W | Start address |
| cmd_size_i | input | 3 | Size code, log2 of bytes per beat |
| cmd_len_i | input | LEN_W | Beat count minus one |
| cmd_burst_i | input | 2 | Burst type |
| err_o | output | 1 | One-cycle pulse for an illegal command |
| beat_valid_o | output | 1 | Beat record valid |
| beat_ready_i | input | 1 | Beat record taken |
| beat_addr_o | output | ADDR_W | Beat address |
| beat_strb_o | output | BUS_BYTES | Byte-lane write strobe |
| beat_last_o | output | 1 | Final beat of the burst |

## Verification
On every cycle, the assertions check the handshake rules: one command at a time, the beat record holding under back-pressure, and return to idle after the final beat. They also check that the lowest strobe bit always sits at the beat's lane, that a fixed burst never moves its address, and that an error pulse never coincides with beats. Only the bench's sweep can show the exact address sequences of incrementing and wrapping bursts, the full strobe widths, the beat counts, and the classification of every illegal case. To do this, it crosses every burst type, size code from 0 to 4, start offset from 0 to 15 and several lengths, under a fluctuating ready pattern.

// File: rtl/bbg_pkg.sv
package bbg_pkg;
  typedef enum logic [1:0] {
    BURST_FIXED = 2'b00,
    BURST_INCR  = 2'b01,
    BURST_WRAP  = 2'b10,
    BURST_RSVD  = 2'b11
  } burst_e;
endpackage

// File: rtl/bbg_cmd_check.sv
module bbg_cmd_check
  import bbg_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int LEN_W     = 8,
  parameter int BUS_BYTES = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        size_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [1:0]        burst_i,
  output logic              legal_o
);
  localparam int MAX_SIZE = $clog2(BUS_BYTES);

  logic [ADDR_W-1:0] size_mask;
  logic unaligned, size_ok, wrap_len_ok;

  always_comb begin
    size_mask   = (ADDR_W'(1) << size_i) - ADDR_W'(1);
    unaligned   = |(addr_i & size_mask);
    size_ok     = ({29'd0, size_i} <= 32'(MAX_SIZE));
    wrap_len_ok = (len_i == LEN_W'(1)) || (len_i == LEN_W'(3)) ||
                  (len_i == LEN_W'(7)) || (len_i == LEN_W'(15));
    unique case (burst_e'(burst_i))
      BURST_FIXED, BURST_INCR: legal_o = size_ok;
      BURST_WRAP:              legal_o = size_ok && !unaligned && wrap_len_ok;
      default:                 legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bbg_next_addr.sv
module bbg_next_addr
  import bbg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        size_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [1:0]        burst_i,
  output logic [ADDR_W-1:0] next_o
);
  logic [ADDR_W-1:0] step, aligned, wrap_mask;

  always_comb begin
    step      = ADDR_W'(1) << size_i;
    aligned   = addr_i & ~(step - ADDR_W'(1));
    // window = beat count * beat size, a power of two for legal wraps
    wrap_mask = ((ADDR_W'(len_i) + ADDR_W'(1)) << size_i) - ADDR_W'(1);
    unique case (burst_e'(burst_i))
      BURST_INCR: next_o = aligned + step;
      BURST_WRAP: next_o = (addr_i & ~wrap_mask) | ((addr_i + step) & wrap_mask);
      default:    next_o = addr_i;
    endcase
  end
endmodule

// File: rtl/bbg_lane_mask.sv
module bbg_lane_mask #(
  parameter int ADDR_W    = 16,
  parameter int BUS_BYTES = 8
) (
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [2:0]           size_i,
  output logic [BUS_BYTES-1:0] strb_o
);
  localparam int LANE_W = $clog2(BUS_BYTES);

  logic [LANE_W:0] pos, step, lo, hi;

  always_comb begin
    pos  = {1'b0, addr_i[LANE_W-1:0]};
    step = (LANE_W+1)'(1) << size_i;
    lo   = pos & ~(step - (LANE_W+1)'(1));
    hi   = lo + step;
  end

  for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
    assign strb_o[i] = ((LANE_W+1)'(i) >= pos) && ((LANE_W+1)'(i) < hi);
  end
endmodule

// File: rtl/burst_beat_gen.sv
module burst_beat_gen
  import bbg_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int LEN_W     = 8,
  parameter int BUS_BYTES = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_valid_i,
  output logic                 cmd_ready_o,
  input  logic [ADDR_W-1:0]    cmd_addr_i,
  input  logic [2:0]           cmd_size_i,
  input  logic [LEN_W-1:0]     cmd_len_i,
  input  logic [1:0]           cmd_burst_i,
  output logic                 err_o,
  output logic                 beat_valid_o,
  input  logic                 beat_ready_i,
  output logic [ADDR_W-1:0]    beat_addr_o,
  output logic [BUS_BYTES-1:0] beat_strb_o,
  output logic                 beat_last_o
);
  logic              busy_q, err_q;
  logic [ADDR_W-1:0] addr_q, addr_nxt;
  logic [2:0]        size_q;
  logic [LEN_W-1:0]  len_q, cnt_q;
  burst_e            burst_q;
  logic              cmd_legal, accept, beat_fire, last_beat;

  bbg_cmd_check #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUS_BYTES(BUS_BYTES)) u_check (
    .addr_i(cmd_addr_i), .size_i(cmd_size_i), .len_i(cmd_len_i),
    .burst_i(cmd_burst_i), .legal_o(cmd_legal)
  );

  bbg_next_addr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_next (
    .addr_i(addr_q), .size_i(size_q), .len_i(len_q),
    .burst_i(burst_q), .next_o(addr_nxt)
  );

  bbg_lane_mask #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u_mask (
    .addr_i(addr_q), .size_i(size_q), .strb_o(beat_strb_o)
  );

  assign cmd_ready_o  = !busy_q;
  assign accept       = cmd_valid_i && cmd_ready_o;
  assign last_beat    = (cnt_q == len_q);
  assign beat_fire    = busy_q && beat_ready_i;
  assign beat_valid_o = busy_q;
  assign beat_addr_o  = addr_q;
  assign beat_last_o  = busy_q && last_beat;
  assign err_o        = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      size_q  <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      burst_q <= BURST_FIXED;
    end else begin
      err_q <= accept && !cmd_legal;
      if (accept && cmd_legal) begin
        busy_q  <= 1'b1;
        addr_q  <= cmd_addr_i;
        size_q  <= cmd_size_i;
        len_q   <= cmd_len_i;
        burst_q <= burst_e'(cmd_burst_i);
        cnt_q   <= '0;
      end else if (beat_fire) begin
        if (last_beat) begin
          busy_q <= 1'b0;
        end else begin
          addr_q <= addr_nxt;
          cnt_q  <= cnt_q + LEN_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/bbg_checker.sv
module bbg_checker #(
  parameter int ADDR_W    = 16,
  parameter int BUS_BYTES = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cmd_ready_o,
  input logic                 err_o,
  input logic                 beat_valid_o,
  input logic                 beat_ready_i,
  input logic [ADDR_W-1:0]    beat_addr_o,
  input logic [BUS_BYTES-1:0] beat_strb_o,
  input logic                 beat_last_o,
  input logic [1:0]           burst_q
);
  localparam int LANE_W = $clog2(BUS_BYTES);

  logic [LANE_W-1:0]    lane;
  logic [BUS_BYTES-1:0] below;
  assign lane  = beat_addr_o[LANE_W-1:0];
  assign below = (BUS_BYTES'(1) << lane) - BUS_BYTES'(1);

  AST_ONE_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o |-> !cmd_ready_o);  // R1
  AST_IDLE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && beat_ready_i && beat_last_o |=> !beat_valid_o && cmd_ready_o);  // R1
  AST_LOW_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o |-> beat_strb_o[lane] && ((beat_strb_o & below) == '0));  // R2
  AST_FIXED_STILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && beat_ready_i && !beat_last_o && burst_q == 2'b00
    |=> $stable(beat_addr_o) && $stable(beat_strb_o));  // R3
  AST_ERR_NO_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !beat_valid_o);  // R6
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && !beat_ready_i |=> beat_valid_o && $stable(beat_addr_o) &&
    $stable(beat_strb_o) && $stable(beat_last_o));  // R7
endmodule

bind burst_beat_gen bbg_checker #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_ready_o(cmd_ready_o), .err_o(err_o),
  .beat_valid_o(beat_valid_o), .beat_ready_i(beat_ready_i),
  .beat_addr_o(beat_addr_o), .beat_strb_o(beat_strb_o),
  .beat_last_o(beat_last_o), .burst_q(burst_q)
);

// File: tb/sim_burst_beat_gen.sv
module sim_burst_beat_gen;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int LEN_W = 8;
  localparam int BUS_BYTES = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [2:0] cmd_size = '0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic [1:0] cmd_burst = '0;
  logic err, beat_valid, beat_ready = 1'b0, beat_last;
  logic [ADDR_W-1:0] beat_addr;
  logic [BUS_BYTES-1:0] beat_strb;

  int n_checks = 0, n_fail = 0, tick = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_beat_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUS_BYTES(BUS_BYTES)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_addr_i(cmd_addr), .cmd_size_i(cmd_size), .cmd_len_i(cmd_len),
    .cmd_burst_i(cmd_burst), .err_o(err), .beat_valid_o(beat_valid),
    .beat_ready_i(beat_ready), .beat_addr_o(beat_addr), .beat_strb_o(beat_strb),
    .beat_last_o(beat_last)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_addr(int start, int size, int len, int burst, int n);
    int bytes = 1 << size;
    int wb = (len + 1) * bytes;
    int base;
    if (burst == 0) return start;
    if (burst == 1) return (n == 0) ? start : (((start / bytes) * bytes + n * bytes) & 16'hFFFF);
    base = (start / wb) * wb;
    return base + ((start - base + n * bytes) % wb);
  endfunction

  function automatic int exp_strb(int a, int size);
    int bytes = 1 << size;
    int pos = a % BUS_BYTES;
    int hi = ((a / bytes) * bytes) % BUS_BYTES + bytes;
    int s = 0;
    for (int i = pos; i < hi; i++) s |= (1 << i);
    return s;
  endfunction

  task automatic run_cmd(input int start, input int size, input int len, input int burst);
    int bytes = 1 << size;
    bit legal;
    int n = 0, guard = 0, ea;
    legal = (burst != 3) && (bytes <= BUS_BYTES) &&
            !(burst == 2 && ((start % bytes) != 0 ||
              !(len == 1 || len == 3 || len == 7 || len == 15)));
    @(negedge clk);
    cmd_addr = ADDR_W'(start); cmd_size = 3'(size);
    cmd_len = LEN_W'(len); cmd_burst = 2'(burst); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (!legal) begin
      check(err === 1'b1 && beat_valid === 1'b0, "R6 err pulse", {err, beat_valid}, 2'b10);
      @(negedge clk);
      check(err === 1'b0 && beat_valid === 1'b0, "R6 err single cycle", {err, beat_valid}, 2'b00);
      return;
    end
    check(err === 1'b0, "R6 no err on legal", err, 0);
    while (n <= len && guard < 400) begin
      tick++; guard++;
      beat_ready = ((tick * 7) % 5) != 0;
      if (beat_valid !== 1'b1) begin
        check(0, "R1 beat missing", beat_valid, 1);
      end else if (beat_ready) begin
        ea = exp_addr(start, size, len, burst, n);
        check(int'(beat_addr) == ea,
              burst == 0 ? "R3 addr" : (burst == 1 ? "R4 addr" : "R5 addr"),
              beat_addr, ea);
        check(int'(beat_strb) == exp_strb(ea, size), "R2 strobe", beat_strb, exp_strb(ea, size));
        check(beat_last === (n == len), "R1 last flag", beat_last, n == len);
        check(cmd_ready === 1'b0, "R1 busy ready", cmd_ready, 0);
        n++;
      end
      @(negedge clk);
    end
    beat_ready = 1'b0;
    check(beat_valid === 1'b0 && cmd_ready === 1'b1, "R1 idle after last",
          {beat_valid, cmd_ready}, 2'b01);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    int lens[5] = '{0, 1, 3, 7, 15};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready === 1'b1 && beat_valid === 1'b0 && err === 1'b0, "R1 reset state",
          {cmd_ready, beat_valid, err}, 3'b100);
    // worked example: 0x03 size 1, four beats
    run_cmd(3, 1, 3, 0);
    run_cmd(3, 1, 3, 1);
    // hold under back-pressure (R7)
    @(negedge clk);
    cmd_addr = 16'h0005; cmd_size = 3'd0; cmd_len = 8'd1; cmd_burst = 2'd1; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(beat_valid === 1'b1 && beat_addr == 16'h0005 && beat_strb == 8'h20,
            "R7 hold", {beat_valid, beat_addr, beat_strb}, {1'b1, 16'h0005, 8'h20});
    end
    beat_ready = 1'b1;
    @(negedge clk);
    check(beat_addr == 16'h0006 && beat_last === 1'b1, "R7 resume", beat_addr, 16'h0006);
    @(negedge clk);
    beat_ready = 1'b0;
    // sweep
    for (int b = 0; b < 4; b++)
      for (int s = 0; s < 5; s++)
        for (int a = 0; a < 16; a++)
          for (int l = 0; l < 5; l++)
            run_cmd(16'h0120 + a, s, lens[l], b);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule